// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers four condition sources of a mixed-signal audio device into a single interrupt line. The four sources are an amplifier fault summary, sample-rate-converter lock, ADC overflow, and channel overflow. Each raw input is brought into the clock domain through a two-flop synchroniser. The synchronised level is published as live status. Its rising edge sets a sticky event bit, which holds until software reads the event register. A per-source enable mask decides which event bits may pull the active-low interrupt output.

The amplifier source is a summary of a separate fault register that holds one sticky bit per fault input. The summary event fires when that register goes from empty to non-empty. It fires again only after the fault register has been read and emptied.

Software uses a small register port. It has one read strobe each for the event, mask, fault and live registers, plus a mask write strobe. Read data appears on the cycle after the strobe. Reading the event or fault register returns its contents and clears them at the same clock edge. An edge that lands on that same edge survives the clear.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the event, mask and fault registers and the read data are 0, and `irq_n_o` is 1.
- R2: An event bit is set only by a 0-to-1 transition of its synchronised source. A source that stays high does not set the bit again after it is cleared. Event register bit positions are: 0 amplifier summary, 1 converter lock, 2 ADC overflow, 3 channel overflow.
- R3: A read strobe on one cycle places that register on `rdata_o` after the next clock edge, zero-extended. A read of the event register clears it at that same edge. `rdata_o` is 0 after a cycle with no read strobe.
- R4: If a source edge would set an event bit at the same edge that an event read clears it, the bit stays set. The read data shows the value from before that edge.
- R5: The amplifier summary event bit is set when the fault register changes from all-zero to non-zero. A further fault that arrives while the register is non-zero and unread does not set the summary again.
- R6: The fault register holds one sticky bit per fault input, at bit position equal to the input index. Each bit is set on a rising edge of that input. A fault register read returns the bits and clears them. A fault held high does not set its bit again.
- R7: Mask bit k (same positions as the event register, written through `mask_wdata_i` with `mask_wr_i`) set to 1 lets event k drive `irq_n_o` low one cycle after both are 1. With mask bit k at 0, event k has no effect on `irq_n_o`.
- R8: Masked sources still set their event bits, and live status keeps following them.
- R9: The channel overflow event is set by a rising edge on any of the channel inputs. Live status bits 2 and up carry each channel's synchronised level, with channel index i at bit 2+i.
- R10: Live status bit 0 is converter lock and bit 1 is ADC overflow. A change on a raw input shows in live status after two clock edges, sets its event at the third, and moves `irq_n_o` at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| amp_fault_i | input | NUM_AMP_FAULTS | Raw amplifier fault conditions |
| src_lock_i | input | 1 | Raw sample-rate-converter lock condition |
| adc_ovfl_i | input | 1 | Raw ADC overflow condition |
| ch_ovfl_i | input | NUM_CH | Raw per-channel overflow conditions |
| evt_rd_i | input | 1 | Read strobe, event register (clear on read) |
| mask_rd_i | input | 1 | Read strobe, mask register |
| fault_rd_i | input | 1 | Read strobe, fault register (clear on read) |
| live_rd_i | input | 1 | Read strobe, live status register |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | Mask write data |
| rdata_o | output | DW | Read data, valid the cycle after a strobe |
| irq_n_o | output | 1 | Interrupt, active low, registered |

## Verification
The bench builds the block with three fault inputs, three channels and an 8-bit read bus. This makes the fault register narrower than its default, and it fills live status up to bit 4, which reaches the channel at the top of the bit range. Reads are issued back to back, so a read strobe can be placed on the exact edge where a synchronised edge sets an event. That covers the set-versus-clear collision and the two-edge and three-edge latencies. Interrupt timing is sampled edge by edge against masks written during the run.

// File: rtl/irq_stat_pkg.sv
// Package: shared constants and types of the interrupt status controller.
// Assumes: exactly four event sources, in fixed bit order.
package irq_stat_pkg;
    localparam int NUM_SRC   = 4;
    localparam int IDX_AMP   = 0;
    localparam int IDX_LOCK  = 1;
    localparam int IDX_ADC   = 2;
    localparam int IDX_CHOV  = 3;
    localparam int LIVE_FIXED = 2;   // lock and ADC bits ahead of channels

    typedef enum logic [2:0] {
        RSEL_NONE  = 3'd0,
        RSEL_EVT   = 3'd1,
        RSEL_MASK  = 3'd2,
        RSEL_FAULT = 3'd3,
        RSEL_LIVE  = 3'd4
    } rsel_e;
endpackage

// File: rtl/irq_sync.sv
// Module: multi-bit level synchroniser.
// What: passes each bit through STAGES flops into the clock domain.
// Assumes: bits are independent slow levels; no bus coherence is needed.
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] stg_q [STAGES];

    // first stage captures the raw input
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // each further stage shifts the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
        end
    end

    assign lvl_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_rise_det.sv
// Module: rising-edge detector.
// What: flags a one-cycle pulse when a synchronised level goes 0 to 1.
// Assumes: input is already in the clock domain.
module irq_rise_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] dly_q;

    // one-cycle delayed copy for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~dly_q;

    // a pulse never lasts two cycles
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_amp_sticky.sv
// Module: amplifier fault register and summary event generator.
// What: one sticky bit per fault input, cleared by its read; raises a
//       summary set pulse when the register goes from empty to non-empty.
// Assumes: rise_i pulses come from the edge detector.
module irq_amp_sticky #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] rise_i,
    input  logic          rd_i,
    output logic [NF-1:0] fault_q_o,
    output logic          sum_set_o
);
    logic [NF-1:0] fault_q;
    logic          held;

    // sticky fault bits: clear on read, new edges win over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (rd_i ? '0 : fault_q) | rise_i;
    end

    // register still occupied after this edge without any new fault
    assign held      = (fault_q != '0) && !rd_i;
    assign sum_set_o = (rise_i != '0) && !held;
    assign fault_q_o = fault_q;

    // a summary pulse always leaves at least one fault bit behind
    p_sum_has_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sum_set_o |=> (fault_q != '0));
    // a read with no new edge empties the register
    p_fault_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rise_i == '0) |=> (fault_q == '0));
    // bits only disappear through a read
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

// File: rtl/irq_evt_bank.sv
// Module: event latches, mask register and interrupt output.
// What: sticky event bits with clear-on-read (set wins), an enable-high
//       mask, and a registered active-low interrupt.
// Assumes: set_i are single-cycle pulses.
module irq_evt_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    input  logic         mask_wr_i,
    input  logic [N-1:0] mask_din_i,
    output logic [N-1:0] evt_q_o,
    output logic [N-1:0] mask_q_o,
    output logic         irq_n_o
);
    logic [N-1:0] evt_q;
    logic [N-1:0] mask_q;
    logic         irq_n_q;

    // event bits: read clears, a coincident set is kept
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (clr_i ? '0 : evt_q) | set_i;
    end

    // mask register, written by software
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= mask_din_i;
    end

    // glitch-free registered interrupt, low when any enabled event is set
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ((evt_q & mask_q) == '0);
    end

    assign evt_q_o  = evt_q;
    assign mask_q_o = mask_q;
    assign irq_n_o  = irq_n_q;

    // without a read, set bits stay set
    p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
    // set coinciding with clear survives
    p_set_beats_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i)));
    // enabled event pulls the interrupt low next cycle
    p_irq_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & mask_q) != '0) |=> !irq_n_o);
    // masked or absent events leave the interrupt high
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & mask_q) == '0) |=> irq_n_o);
    // masking does not block latching
    p_masked_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((evt_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_read_port.sv
// Module: registered read multiplexer.
// What: returns the strobed register, zero-extended, one cycle later.
// Assumes: one strobe at a time; if several, event > mask > fault > live.
module irq_read_port
    import irq_stat_pkg::*;
#(
    parameter int DW = 8,
    parameter int EW = 4,
    parameter int FW = 4,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_rd_i,
    input  logic          mask_rd_i,
    input  logic          fault_rd_i,
    input  logic          live_rd_i,
    input  logic [EW-1:0] evt_i,
    input  logic [EW-1:0] mask_i,
    input  logic [FW-1:0] fault_i,
    input  logic [LW-1:0] live_i,
    output logic [DW-1:0] rdata_o
);
    rsel_e         sel;
    logic [DW-1:0] nxt;
    logic [DW-1:0] rdata_q;

    // pick which register the strobes address
    always_comb begin
        if      (evt_rd_i)   sel = RSEL_EVT;
        else if (mask_rd_i)  sel = RSEL_MASK;
        else if (fault_rd_i) sel = RSEL_FAULT;
        else if (live_rd_i)  sel = RSEL_LIVE;
        else                 sel = RSEL_NONE;
    end

    // zero-extend the chosen register
    always_comb begin
        unique case (sel)
            RSEL_EVT:   nxt = DW'(evt_i);
            RSEL_MASK:  nxt = DW'(mask_i);
            RSEL_FAULT: nxt = DW'(fault_i);
            RSEL_LIVE:  nxt = DW'(live_i);
            default:    nxt = '0;
        endcase
    end

    // hold read data for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= nxt;
    end

    assign rdata_o = rdata_q;

    // idle cycles return zero
    p_idle_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_rd_i || mask_rd_i || fault_rd_i || live_rd_i) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: latched interrupt status controller (top).
// What: synchronises four condition sources, latches their rising edges
//       as sticky events, masks them into one active-low interrupt, and
//       exposes event, mask, fault and live registers through strobes.
// Assumes: raw inputs are asynchronous levels; DW fits every register.
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int NUM_AMP_FAULTS = 4,
    parameter int NUM_CH         = 3,
    parameter int DW             = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_AMP_FAULTS-1:0] amp_fault_i,
    input  logic                      src_lock_i,
    input  logic                      adc_ovfl_i,
    input  logic [NUM_CH-1:0]         ch_ovfl_i,
    input  logic                      evt_rd_i,
    input  logic                      mask_rd_i,
    input  logic                      fault_rd_i,
    input  logic                      live_rd_i,
    input  logic                      mask_wr_i,
    input  logic [NUM_SRC-1:0]        mask_wdata_i,
    output logic [DW-1:0]             rdata_o,
    output logic                      irq_n_o
);
    localparam int LW = LIVE_FIXED + NUM_CH;

    logic [NUM_AMP_FAULTS-1:0] amp_lvl, amp_rise, fault_q;
    logic [LW-1:0]             live_lvl, live_rise;
    logic [NUM_SRC-1:0]        evt_set, evt_q, mask_q;
    logic                      sum_set;

    irq_sync #(.W(NUM_AMP_FAULTS), .STAGES(SYNC_STAGES)) u_amp_sync (
        .clk(clk), .rst_n(rst_n), .din(amp_fault_i), .lvl_o(amp_lvl));

    irq_rise_det #(.W(NUM_AMP_FAULTS)) u_amp_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(amp_lvl), .rise_o(amp_rise));

    irq_sync #(.W(LW), .STAGES(SYNC_STAGES)) u_live_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ch_ovfl_i, adc_ovfl_i, src_lock_i}), .lvl_o(live_lvl));

    irq_rise_det #(.W(LW)) u_live_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(live_lvl), .rise_o(live_rise));

    irq_amp_sticky #(.NF(NUM_AMP_FAULTS)) u_amp (
        .clk(clk), .rst_n(rst_n), .rise_i(amp_rise), .rd_i(fault_rd_i),
        .fault_q_o(fault_q), .sum_set_o(sum_set));

    // map edges onto the event bit positions
    always_comb begin
        evt_set           = '0;
        evt_set[IDX_AMP]  = sum_set;
        evt_set[IDX_LOCK] = live_rise[0];
        evt_set[IDX_ADC]  = live_rise[1];
        evt_set[IDX_CHOV] = |live_rise[LW-1:LIVE_FIXED];
    end

    irq_evt_bank #(.N(NUM_SRC)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(evt_rd_i),
        .mask_wr_i(mask_wr_i), .mask_din_i(mask_wdata_i),
        .evt_q_o(evt_q), .mask_q_o(mask_q), .irq_n_o(irq_n_o));

    irq_read_port #(.DW(DW), .EW(NUM_SRC), .FW(NUM_AMP_FAULTS), .LW(LW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .evt_rd_i(evt_rd_i), .mask_rd_i(mask_rd_i),
        .fault_rd_i(fault_rd_i), .live_rd_i(live_rd_i),
        .evt_i(evt_q), .mask_i(mask_q), .fault_i(fault_q), .live_i(live_lvl),
        .rdata_o(rdata_o));

    // channel event follows a channel edge (R9)
    p_chov_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_rise[LW-1:LIVE_FIXED] != '0) |=> evt_q[IDX_CHOV]);
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
    localparam int NF = 3;
    localparam int NC = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NF-1:0] amp_fault;
    logic          src_lock, adc_ovfl;
    logic [NC-1:0] ch_ovfl;
    logic          evt_rd, mask_rd, fault_rd, live_rd, mask_wr;
    logic [3:0]    mask_wdata;
    logic [DW-1:0] rdata;
    logic          irq_n;

    always #2 clk = ~clk;

    irq_status_ctrl #(.NUM_AMP_FAULTS(NF), .NUM_CH(NC), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .amp_fault_i(amp_fault),
        .src_lock_i(src_lock), .adc_ovfl_i(adc_ovfl), .ch_ovfl_i(ch_ovfl),
        .evt_rd_i(evt_rd), .mask_rd_i(mask_rd), .fault_rd_i(fault_rd),
        .live_rd_i(live_rd), .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
        .rdata_o(rdata), .irq_n_o(irq_n));

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    logic  pend_q = 1'b0;
    bit    done   = 1'b0;

    localparam int EVT = 0, MSK = 1, FLT = 2, LIV = 3;

    // monitor: note read strobes at the edge, compare data half a cycle later
    always @(posedge clk) pend_q <= evt_rd | mask_rd | fault_rd | live_rd;

    always @(negedge clk) begin
        item_t it;
        if (pend_q) begin
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: unexpected read data %h expected none", rdata);
            end else begin
                it = q.pop_front();
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: push the expected word and strobe for one cycle
    task automatic rd(input int which, input logic [DW-1:0] e, input string t);
        q.push_back(item_t'{exp: e, tag: t});
        evt_rd = 0; mask_rd = 0; fault_rd = 0; live_rd = 0;
        case (which)
            EVT: evt_rd = 1'b1;
            MSK: mask_rd = 1'b1;
            FLT: fault_rd = 1'b1;
            default: live_rd = 1'b1;
        endcase
        @(negedge clk);
        evt_rd = 0; mask_rd = 0; fault_rd = 0; live_rd = 0;
    endtask

    task automatic wr_mask(input logic [3:0] m);
        mask_wr = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq_n !== e) begin
            n_fail++;
            $display("FAIL %s: got irq_n=%b expected %b", t, irq_n, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; amp_fault = '0; src_lock = 0; adc_ovfl = 0; ch_ovfl = '0;
        evt_rd = 0; mask_rd = 0; fault_rd = 0; live_rd = 0; mask_wr = 0;
        mask_wdata = '0;
        tick(4);
        rst_n = 1;
        chk_irq(1'b1, "R1 reset irq");
        n_chk++;
        if (rdata !== '0) begin
            n_fail++; $display("FAIL R1 reset rdata: got %h expected 00", rdata);
        end
        rd(EVT, 8'h00, "R1 reset event");
        rd(MSK, 8'h00, "R1 reset mask");
        rd(FLT, 8'h00, "R1 reset fault");
        rd(LIV, 8'h00, "R1 reset live");

        // R10 latency and R2 edge behaviour on converter lock
        src_lock = 1;
        tick(1);
        rd(LIV, 8'h00, "R10 live after one edge");
        rd(LIV, 8'h01, "R10 live after two edges");
        rd(EVT, 8'h02, "R10 R2 lock event at third edge");
        rd(EVT, 8'h00, "R3 cleared, R2 level does not re-set");
        chk_irq(1'b1, "R8 unmasked none");

        // R4 read coinciding with set
        adc_ovfl = 1;
        tick(2);
        rd(EVT, 8'h00, "R4 read on set edge returns old");
        rd(EVT, 8'h04, "R4 event kept");
        rd(EVT, 8'h00, "R3 event cleared");
        rd(LIV, 8'h03, "R10 live lock and adc");

        // R7 interrupt path and timing
        adc_ovfl = 0;
        tick(6);
        wr_mask(4'b0100);
        rd(MSK, 8'h04, "R7 mask readback");
        adc_ovfl = 1;
        tick(3);
        chk_irq(1'b1, "R10 irq not yet at third edge");
        tick(1);
        chk_irq(1'b0, "R7 irq at fourth edge");
        rd(EVT, 8'h04, "R7 event read");
        chk_irq(1'b0, "R7 irq still low on clear edge");
        tick(1);
        chk_irq(1'b1, "R7 irq released after clear");

        // R8 masked source still latches
        src_lock = 0;
        tick(4);
        src_lock = 1;
        tick(6);
        chk_irq(1'b1, "R8 masked lock keeps irq high");
        wr_mask(4'b0110);
        tick(1);
        chk_irq(1'b0, "R7 unmask latched event");
        rd(EVT, 8'h02, "R8 masked event latched");
        tick(2);
        chk_irq(1'b1, "R7 irq high after clear");

        // R9 channel overflow
        ch_ovfl = 3'b100;
        tick(4);
        rd(LIV, 8'h13, "R9 sub channel live");
        rd(EVT, 8'h08, "R9 channel event");
        ch_ovfl = 3'b101;
        tick(4);
        rd(EVT, 8'h08, "R9 second channel event");
        rd(LIV, 8'h17, "R9 live per channel");
        chk_irq(1'b1, "R7 channel masked");

        // R5 R6 amplifier fault summary
        amp_fault = 3'b001;
        tick(4);
        rd(EVT, 8'h01, "R5 summary set");
        amp_fault = 3'b011;
        tick(4);
        rd(EVT, 8'h00, "R5 no summary while fault register occupied");
        rd(FLT, 8'h03, "R6 fault bits");
        rd(FLT, 8'h00, "R6 cleared, held level no re-set");
        amp_fault = 3'b010;
        tick(4);
        amp_fault = 3'b011;
        tick(4);
        rd(EVT, 8'h01, "R5 summary re-armed");
        rd(FLT, 8'h01, "R6 new fault bit");

        // R1 reset mid-run
        rst_n = 0;
        tick(2);
        rst_n = 1;
        chk_irq(1'b1, "R1 irq after reset");
        rd(MSK, 8'h00, "R1 mask after reset");
        rd(FLT, 8'h00, "R1 fault after reset");

        tick(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule